// File: doc/BRIEF.md
# SPI Command Register Receiver

This block sits on the slave side of a serial link from a host controller. It receives 16-bit command words over SPI mode 0: the clock idles low and each data bit is taken on the rising SCK edge. It decodes each word and updates one of a small set of configuration registers. The top four bits of a word select the target register and the lower twelve bits carry the value. The outputs are registered and drive the rest of the chip directly: a 3-bit major mode, a 6-bit minor mode, a clock divisor, an edge-detect threshold and a trace-enable flag.

SCK, MOSI and the active-low chip select are brought into the system clock domain through two-flop synchronisers, and SCK edges are found there. The system clock must therefore run at least eight times faster than SCK. A word takes effect only when chip select is released after exactly sixteen captured bits. The build parameter `HF_BUILD` sets the meaning of command 2. With `HF_BUILD` = 0 it loads the divisor. With `HF_BUILD` = 1 it loads the trace-enable flag.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, major_o is 7, minor_o, divisor_o and threshold_o are 0, trace_en_o is 0, mode_off_o is 1 and upd_o is 0.
- R2: Bits are shifted in MSB first on each rising SCK edge while chip select is low. Bits [15:12] of the word are the command code and bits [11:0] are the payload.
- R3: Code 1 loads major_o from payload bits [8:6] and minor_o from payload bits [5:0]. Payload bits [11:9] are ignored.
- R4: With HF_BUILD = 0, code 2 loads divisor_o with the full 12-bit payload and leaves trace_en_o unchanged.
- R5: With HF_BUILD = 1, code 2 loads trace_en_o from payload bit 0 and leaves divisor_o unchanged.
- R6: Code 3 loads threshold_o with the full 12-bit payload.
- R7: Codes 0 and 4 to 15 change no output and produce no upd_o pulse.
- R8: A frame whose bit count between chip-select assertion and release is not 16 (for example 0, 15 or 17) is discarded.
- R9: upd_o is high for exactly one system clock cycle for each accepted word with code 1, 2 or 3.
- R10: mode_off_o is 1 exactly when major_o equals 7.
- R11: A rising SCK edge that reaches the system clock domain in the same cycle as the chip-select release still counts as a bit of the frame being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock, idle low |
| mosi_i | input | 1 | SPI data from host |
| cs_n_i | input | 1 | SPI chip select, active low |
| major_o | output | 3 | Major mode |
| minor_o | output | 6 | Minor mode |
| divisor_o | output | 12 | Clock divisor |
| threshold_o | output | 12 | Edge-detect threshold |
| trace_en_o | output | 1 | Trace enable flag |
| mode_off_o | output | 1 | High while major mode is off (7) |
| upd_o | output | 1 | One-cycle strobe on each register write |

## Verification
Two events can land in the same system clock cycle: the capture of the final data bit on a rising SCK edge, and the frame commit triggered by chip-select release. The bench provokes this by raising SCK and chip select in the same instant for the sixteenth bit. Both inputs pass through synchronisers of equal depth, so both edges are seen in one cycle. The result is judged at the outputs: the threshold must take the full word, including its last bit, and exactly one update strobe must appear. A frame dropped because of a miscount would leave the threshold at its old value.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W    = 16;
  localparam int CODE_W    = 4;
  localparam int MAJ_W     = 3;
  localparam int MIN_W     = 6;
  localparam int CMD_CONF  = 1;
  localparam int CMD_DIVTR = 2;
  localparam int CMD_THR   = 3;
  localparam int MAJ_OFF   = 7;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_CONF = 2'd1,
    WR_DIVT = 2'd2,
    WR_THR  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              cs_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sck_q, cs_n_q;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sck_rise, cs_rise, cs_fall, capture, commit;

  assign sck_rise = sck_i & ~sck_q;
  assign cs_rise  = cs_n_i & ~cs_n_q;
  assign cs_fall  = ~cs_n_i & cs_n_q;
  // selection judged on the previous cycle so a bit coincident with release counts
  assign capture  = sck_rise & ~cs_n_q;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (cs_fall) begin
      cnt_d = '0;
    end else if (capture) begin
      shift_d = {shift_q[WORD_W-2:0], mosi_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  assign commit = cs_rise & (cnt_d == CNT_W'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      shift_q    <= '0;
      cnt_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      sck_q      <= sck_i;
      cs_n_q     <= cs_n_i;
      shift_q    <= shift_d;
      cnt_q      <= cnt_d;
      word_vld_o <= commit;
      if (commit) word_o <= shift_d;
    end
  end

  // R8
  commit_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(cs_n_i));
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));
  // R9
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CODE_W   = 4,
  parameter int MAJ_W    = 3,
  parameter int MIN_W    = 6,
  parameter bit HF_BUILD = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_W-1:0]     word_i,
  input  logic                  word_vld_i,
  output logic [MAJ_W-1:0]      major_o,
  output logic [MIN_W-1:0]      minor_o,
  output logic [WORD_W-CODE_W-1:0] divisor_o,
  output logic [WORD_W-CODE_W-1:0] threshold_o,
  output logic                  trace_en_o,
  output logic                  upd_o
);
  localparam int PAY_W = WORD_W - CODE_W;

  logic [CODE_W-1:0] code;
  logic [PAY_W-1:0]  payload;
  wr_sel_e           sel;
  logic              we_div, we_trace;

  assign code    = word_i[WORD_W-1 -: CODE_W];
  assign payload = word_i[PAY_W-1:0];

  always_comb begin
    sel = WR_NONE;
    if (word_vld_i) begin
      if (code == CODE_W'(CMD_CONF))       sel = WR_CONF;
      else if (code == CODE_W'(CMD_DIVTR)) sel = WR_DIVT;
      else if (code == CODE_W'(CMD_THR))   sel = WR_THR;
    end
  end

  generate
    if (HF_BUILD) begin : g_hf
      assign we_div   = 1'b0;
      assign we_trace = (sel == WR_DIVT);
    end else begin : g_lf
      assign we_div   = (sel == WR_DIVT);
      assign we_trace = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      major_o     <= MAJ_W'(MAJ_OFF);
      minor_o     <= '0;
      divisor_o   <= '0;
      threshold_o <= '0;
      trace_en_o  <= 1'b0;
      upd_o       <= 1'b0;
    end else begin
      upd_o <= (sel != WR_NONE);
      if (sel == WR_CONF) begin
        major_o <= payload[MIN_W +: MAJ_W];
        minor_o <= payload[MIN_W-1:0];
      end
      if (we_div)          divisor_o   <= payload;
      if (we_trace)        trace_en_o  <= payload[0];
      if (sel == WR_THR)   threshold_o <= payload;
    end
  end

  // R7
  unknown_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !(word_i[WORD_W-1 -: CODE_W] inside {4'd1, 4'd2, 4'd3}))
    |=> ($stable(major_o) && $stable(minor_o) && $stable(divisor_o) &&
         $stable(threshold_o) && $stable(trace_en_o) && !upd_o));
  // R9
  upd_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(word_vld_i));
  // R4
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_div, we_trace}));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit HF_BUILD    = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        mosi_i,
  input  logic        cs_n_i,
  output logic [2:0]  major_o,
  output logic [5:0]  minor_o,
  output logic [11:0] divisor_o,
  output logic [11:0] threshold_o,
  output logic        trace_en_o,
  output logic        mode_off_o,
  output logic        upd_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  spi_cmd_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_n_i, sck_i, mosi_i}),
    .q_o    (pins_s)
  );

  spi_cmd_frame #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (pins_s[1]),
    .mosi_i     (pins_s[0]),
    .cs_n_i     (pins_s[2]),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  spi_cmd_regs #(
    .WORD_W   (WORD_W),
    .CODE_W   (CODE_W),
    .MAJ_W    (MAJ_W),
    .MIN_W    (MIN_W),
    .HF_BUILD (HF_BUILD)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word),
    .word_vld_i  (word_vld),
    .major_o     (major_o),
    .minor_o     (minor_o),
    .divisor_o   (divisor_o),
    .threshold_o (threshold_o),
    .trace_en_o  (trace_en_o),
    .upd_o       (upd_o)
  );

  assign mode_off_o = (major_o == 3'(MAJ_OFF));

  // R3
  conf_from_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word[15:12] == 4'd1) |=> (major_o == $past(word[8:6]) && minor_o == $past(word[5:0])));
  // R6
  thr_from_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word[15:12] == 4'd3) |=> (threshold_o == $past(word[11:0])));
endmodule

// File: tb/spi_cmd_rx_bench.sv
module spi_cmd_rx_bench;
  localparam time CLK_P = 10ns;
  localparam int  HALF  = 8;
  localparam int  NVEC  = 11;
  // {nbits[4:0], word[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd16, 16'h10A5}, {5'd16, 16'h23C4}, {5'd16, 16'h37FF}, {5'd16, 16'h0FFF},
    {5'd16, 16'h9123}, {5'd15, 16'h3111}, {5'd17, 16'h2555}, {5'd16, 16'h2001},
    {5'd16, 16'h1FC0}, {5'd16, 16'hF000}, {5'd16, 16'h1E7F}
  };

  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, cs_n = 1;
  logic [2:0] maj_l, maj_h;  logic [5:0] min_l, min_h;
  logic [11:0] div_l, div_h, thr_l, thr_h;
  logic tr_l, tr_h, off_l, off_h, upd_l, upd_h;

  int checks = 0, errors = 0;
  int n_upd_l = 0, n_upd_h = 0, wid_err = 0;
  logic prev_l = 0, prev_h = 0;
  // reference model
  logic [2:0] m_maj; logic [5:0] m_min; logic [11:0] m_div_l, m_thr; logic m_tr_h;
  int m_upd = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_rx #(.HF_BUILD(1'b0)) u_spi_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_n_i(cs_n),
    .major_o(maj_l), .minor_o(min_l), .divisor_o(div_l), .threshold_o(thr_l),
    .trace_en_o(tr_l), .mode_off_o(off_l), .upd_o(upd_l));

  spi_cmd_rx #(.HF_BUILD(1'b1)) u_spi_cmd_rx_hf (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_n_i(cs_n),
    .major_o(maj_h), .minor_o(min_h), .divisor_o(div_h), .threshold_o(thr_h),
    .trace_en_o(tr_h), .mode_off_o(off_h), .upd_o(upd_h));

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_l) n_upd_l++;
      if (upd_h) n_upd_h++;
      if (upd_l && prev_l) wid_err++;
      if (upd_h && prev_h) wid_err++;
    end
    prev_l = upd_l;
    prev_h = upd_h;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_maj = 3'd7; m_min = '0; m_div_l = '0; m_thr = '0; m_tr_h = 1'b0;
  endtask

  task automatic model_apply(logic [15:0] w, int nb);
    if (nb != 16) return;                       // R8
    case (w[15:12])
      4'd1: begin m_maj = w[8:6]; m_min = w[5:0]; m_upd++; end
      4'd2: begin m_div_l = w[11:0]; m_tr_h = w[0]; m_upd++; end
      4'd3: begin m_thr = w[11:0]; m_upd++; end
      default: ;                                // R7
    endcase
  endtask

  task automatic check_all(string req);
    check({req, " major"},   32'(maj_l), 32'(m_maj));
    check({req, " minor"},   32'(min_l), 32'(m_min));
    check({req, " R4 div"},  32'(div_l), 32'(m_div_l));
    check({req, " R6 thr"},  32'(thr_l), 32'(m_thr));
    check({req, " R4 trace"}, 32'(tr_l), 32'd0);
    check({req, " hf major"}, 32'(maj_h), 32'(m_maj));
    check({req, " hf minor"}, 32'(min_h), 32'(m_min));
    check({req, " R5 div"},  32'(div_h), 32'd0);
    check({req, " R5 trace"}, 32'(tr_h), 32'(m_tr_h));
    check({req, " hf thr"},  32'(thr_h), 32'(m_thr));
    check({req, " R10 off"}, 32'(off_l), 32'(m_maj == 3'd7));
    check({req, " R10 off hf"}, 32'(off_h), 32'(m_maj == 3'd7));
    check({req, " R9 upd"},  32'(n_upd_l), 32'(m_upd));
    check({req, " R9 upd hf"}, 32'(n_upd_h), 32'(m_upd));
  endtask

  // tie_last: final rising SCK edge coincides with chip-select release
  task automatic send_frame(logic [15:0] w, int nb, bit tie_last);
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (tie_last && i == nb - 1) begin
        sck = 1; cs_n = 1;
        repeat (HALF) @(negedge clk);
        sck = 0;
      end else begin
        sck = 1;
        repeat (HALF) @(negedge clk);
        sck = 0;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 major", 32'(maj_l), 32'd7);
    check("R1 minor", 32'(min_l), 32'd0);
    check("R1 off", 32'(off_l), 32'd1);
    check("R1 upd", 32'(upd_l), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int k = 0; k < NVEC; k++) begin
      send_frame(VEC[k][15:0], int'(VEC[k][20:16]), 1'b0);
      model_apply(VEC[k][15:0], int'(VEC[k][20:16]));
      check_all("R2 vec");
    end

    // R8 empty frame
    send_frame(16'h3ABC, 0, 1'b0);
    check_all("R8 empty");

    // R11 last bit coincides with release
    send_frame(16'h30AB, 16, 1'b1);
    model_apply(16'h30AB, 16);
    check_all("R11 tie");
    check("R11 thr", 32'(thr_l), 32'h0AB);

    // R9 strobe width
    check("R9 width", 32'(wid_err), 32'd0);

    // R1 reset after activity
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    model_reset();
    check("R1 re major", 32'(maj_h), 32'd7);
    check("R1 re thr", 32'(thr_l), 32'd0);
    check("R1 re div", 32'(div_l), 32'd0);
    check("R1 re trace", 32'(tr_h), 32'd0);
    check("R1 re off", 32'(off_h), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule